// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the clocks of an audio serial link in master mode from one kernel clock. An 8-bit divide value and an odd bit set a linear stage of ratio 2·D + odd kernel cycles, with a duty correction that keeps the two phases of an odd ratio within one kernel cycle of each other. The linear stage drives the optional master clock. A post stage then makes the bit clock: divide by 4 when the master clock is output, or divide by 1 or 2 chosen by the channel length otherwise. A path bit can bypass the post stage so that the bit clock comes straight from the linear stage.

Word select marks the channel and flips once per channel, on a falling edge of the bit clock, after 16 or 32 bit periods. With two channels the frame is 32 or 64 bit periods per sample, so the bit rate is bits per channel × 2 × the sample rate. All outputs are registers clocked by the kernel clock. Configuration is taken while the block is disabled and held while it runs.

Top module: `audio_clkgen`

## Requirements
- R1: With the master clock output enabled, `mck_o` has a period of N = 2·D + `odd_i` kernel cycles. It is high for the first D + `odd_i` cycles and low for the remaining D cycles, where D is the divide value after the R2 clamp.
- R2: A divide value of 0 or 1 is treated as 2, and `cfg_err_o` is 1 for as long as that value is the effective one. For values of 2 and above `cfg_err_o` is 0.
- R3: The bit clock period is N·P kernel cycles. P is 1 when `post_i`=0. When `post_i`=1, P is 4 if `mck_oe_i`=1, 1 if `ch32_i`=1, and 2 otherwise.
- R4: The bit clock is high first in each period. For P=1 it is high for D + `odd_i` cycles; for P=2 or 4 it is high for exactly half the period.
- R5: `ws_o` changes only in the cycle in which `bck_o` falls. It flips at the falling edge of the last bit of each channel, where a channel is 16 bit periods (`ch32_i`=0) or 32 bit periods (`ch32_i`=1).
- R6: `mck_o` stays low whenever the master clock output enable is clear.
- R7: While `en` is low, `mck_o`, `bck_o` and `ws_o` are low and every counter is at zero. Outputs are low in the first cycle after `en` falls.
- R8: Configuration inputs that change while `en` is high have no effect. They take effect at the next rising of `en`.
- R9: In the first cycle after `en` rises, `bck_o` is high, `ws_o` is low, and `mck_o` equals the master clock output enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | kernel clock |
| rst_n | input | 1 | asynchronous active-low reset |
| en | input | 1 | run enable; the configuration is sampled while low |
| div_i | input | 8 | linear divide value D |
| odd_i | input | 1 | adds one kernel cycle to the linear ratio |
| mck_oe_i | input | 1 | master clock output enable |
| ch32_i | input | 1 | channel length: 1 = 32 bits, 0 = 16 bits |
| post_i | input | 1 | 1 = bit clock through the post stage, 0 = straight from the linear stage |
| mck_o | output | 1 | master clock |
| bck_o | output | 1 | bit clock |
| ws_o | output | 1 | word select |
| cfg_err_o | output | 1 | effective divide value was clamped to 2 |

## Verification
The bench compares every cycle of all three clocks against a per-cycle model, so a phase that is off by one on odd ratios, or a post-divider that picks the wrong path, shows up as a mismatch in the very first period. It aims at divide values of 0 and 1, which would give a stalled or over-fast clock if the clamp were missing. It also drives the odd bit at the extreme value 255, where a counter that is too narrow would wrap early. A word-select that flips on a rising edge, or one bit early, is caught at the first channel boundary. Configuration is changed in the middle of a run, so a design that does not latch it would change frequency at that point.

// File: rtl/audio_clkgen.sv
module audio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_i,
  input  logic             odd_i,
  input  logic             mck_oe_i,
  input  logic             ch32_i,
  input  logic             post_i,
  output logic             mck_o,
  output logic             bck_o,
  output logic             ws_o,
  output logic             cfg_err_o
);
  localparam int NW = DIV_W + 1;
  localparam int BW = NW + 2;
  localparam int KW = 5;

  logic             run;
  logic [DIV_W-1:0] s_div;
  logic             s_odd, s_mck, s_ch32, s_post;
  logic [NW-1:0]    c_q, c_n;
  logic [BW-1:0]    t_q, t_n;
  logic [KW-1:0]    k_q, k_n;

  logic [DIV_W-1:0] e_div;
  logic             e_odd, e_mck, e_ch32, e_post;
  assign e_div  = run ? s_div  : div_i;
  assign e_odd  = run ? s_odd  : odd_i;
  assign e_mck  = run ? s_mck  : mck_oe_i;
  assign e_ch32 = run ? s_ch32 : ch32_i;
  assign e_post = run ? s_post : post_i;

  logic             clamp;
  logic [DIV_W-1:0] d_eff;
  logic [NW-1:0]    n_val, h_val;
  logic [1:0]       psh;
  logic [BW-1:0]    b_val, hb_val;
  logic [KW-1:0]    k_last;

  assign clamp  = (e_div < DIV_W'(2));
  assign d_eff  = clamp ? DIV_W'(2) : e_div;
  assign n_val  = {d_eff, 1'b0} + NW'(e_odd);
  assign h_val  = NW'(d_eff) + NW'(e_odd);
  assign psh    = !e_post ? 2'd0 : (e_mck ? 2'd2 : (e_ch32 ? 2'd0 : 2'd1));
  assign b_val  = BW'(n_val) << psh;
  assign hb_val = (psh == 2'd0) ? BW'(h_val) : (b_val >> 1);
  assign k_last = e_ch32 ? KW'(31) : KW'(15);
  assign cfg_err_o = clamp;

  always_comb begin
    c_n = '0;
    t_n = '0;
    k_n = '0;
    if (run) begin
      c_n = (c_q == n_val - NW'(1)) ? '0 : c_q + NW'(1);
      t_n = (t_q == b_val - BW'(1)) ? '0 : t_q + BW'(1);
      k_n = k_q;
      if (t_q == b_val - BW'(1))
        k_n = (k_q == k_last) ? '0 : k_q + KW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      s_div  <= '0;
      s_odd  <= 1'b0;
      s_mck  <= 1'b0;
      s_ch32 <= 1'b0;
      s_post <= 1'b0;
    end else begin
      run <= en;
      if (!run) begin
        s_div  <= div_i;
        s_odd  <= odd_i;
        s_mck  <= mck_oe_i;
        s_ch32 <= ch32_i;
        s_post <= post_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q   <= '0;
      t_q   <= '0;
      k_q   <= '0;
      mck_o <= 1'b0;
      bck_o <= 1'b0;
      ws_o  <= 1'b0;
    end else if (!en) begin
      c_q   <= '0;
      t_q   <= '0;
      k_q   <= '0;
      mck_o <= 1'b0;
      bck_o <= 1'b0;
      ws_o  <= 1'b0;
    end else begin
      c_q   <= c_n;
      t_q   <= t_n;
      k_q   <= k_n;
      mck_o <= e_mck && (c_n < h_val);
      bck_o <= (t_n < hb_val);
      if (run && (t_n == hb_val) && (k_q == k_last))
        ws_o <= ~ws_o;
    end
  end

  // R5
  p_ws_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && (ws_o != $past(ws_o))) |-> $fell(bck_o));

  // R6
  p_mck_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !s_mck) |-> !mck_o);

  // R7
  p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!mck_o && !bck_o && !ws_o));

  // R8
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> ($stable(s_div) && $stable(s_odd) && $stable(s_mck)
                             && $stable(s_ch32) && $stable(s_post)));

  // R9
  p_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (bck_o && !ws_o && (mck_o == s_mck)));
endmodule

// File: tb/audio_clkgen_bench.sv
module audio_clkgen_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [7:0] div_i = 8'd2;
  logic odd_i = 1'b0, mck_oe_i = 1'b0, ch32_i = 1'b0, post_i = 1'b0;
  logic mck_o, bck_o, ws_o, cfg_err_o;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_clkgen u_audio_clkgen (
    .clk(clk), .rst_n(rst_n), .en(en), .div_i(div_i), .odd_i(odd_i),
    .mck_oe_i(mck_oe_i), .ch32_i(ch32_i), .post_i(post_i),
    .mck_o(mck_o), .bck_o(bck_o), .ws_o(ws_o), .cfg_err_o(cfg_err_o));

  function automatic int f_d(int d); return (d < 2) ? 2 : d; endfunction
  function automatic int f_n(int d, int o); return 2 * f_d(d) + o; endfunction
  function automatic int f_p(int post, int mck, int c32);
    if (post == 0) return 1;
    if (mck != 0) return 4;
    return (c32 != 0) ? 1 : 2;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_case(int d, int o, int m, int c32, int post, int limit, bit poke);
    int n, h, p, b, hb, len, ws_e;
    int bad_m, bad_b, bad_w, bad_e, am, em, ab, eb, aw, ew;
    n = f_n(d, o); h = f_d(d) + o; p = f_p(post, m, c32);
    b = n * p; hb = (p == 1) ? h : b / 2; len = (c32 != 0) ? 32 : 16;
    @(negedge clk);
    div_i = 8'(d); odd_i = o[0]; mck_oe_i = m[0]; ch32_i = c32[0]; post_i = post[0];
    #1 check("R2 cfg_err idle", int'(cfg_err_o), (d < 2) ? 1 : 0);
    en = 1'b1;
    ws_e = 0; bad_m = 0; bad_b = 0; bad_w = 0; bad_e = 0;
    am = 0; em = 0; ab = 0; eb = 0; aw = 0; ew = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (i == 0) begin
        check("R9 bck at start", int'(bck_o), 1);
        check("R9 ws at start", int'(ws_o), 0);
        check("R9 mck at start", int'(mck_o), m);
      end
      if ((i % b) == hb && ((i / b) % len) == len - 1) ws_e = 1 - ws_e;
      if (int'(mck_o) != ((m != 0 && (i % n) < h) ? 1 : 0)) begin
        if (bad_m == 0) begin am = int'(mck_o); em = 1 - am; end
        bad_m++;
      end
      if (int'(bck_o) != (((i % b) < hb) ? 1 : 0)) begin
        if (bad_b == 0) begin ab = int'(bck_o); eb = 1 - ab; end
        bad_b++;
      end
      if (int'(ws_o) != ws_e) begin
        if (bad_w == 0) begin aw = int'(ws_o); ew = ws_e; end
        bad_w++;
      end
      if (int'(cfg_err_o) != ((d < 2) ? 1 : 0)) bad_e++;
      if (poke && i == limit / 3) begin
        div_i = 8'(d + 7); odd_i = ~odd_i; mck_oe_i = ~mck_oe_i;
        ch32_i = ~ch32_i; post_i = ~post_i;
      end
    end
    check($sformatf("R1/R6 mck d=%0d o=%0d m=%0d first", d, o, m), am, em);
    check("R1/R6 mck mismatch cycles", bad_m, 0);
    check($sformatf("R3/R4 bck d=%0d p=%0d first", d, p), ab, eb);
    check("R3/R4 bck mismatch cycles", bad_b, 0);
    check("R5 ws first", aw, ew);
    check("R5 ws mismatch cycles", bad_w, 0);
    check("R2 cfg_err running", bad_e, 0);
    if (poke) check("R8 mid-run change ignored", bad_m + bad_b + bad_w, 0);
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    check("R7 idle outputs", int'({mck_o, bck_o, ws_o}), 0);
  endtask

  initial begin
    int guard = 0;
    while (!done) begin
      @(posedge clk);
      guard++;
      if (guard > 190000) begin
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<190000", guard);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R7 reset outputs", int'({mck_o, bck_o, ws_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 idle after reset", int'({mck_o, bck_o, ws_o}), 0);
    run_case(0, 0, 1, 0, 1, 3000, 1'b0);
    run_case(1, 1, 0, 0, 1, 3000, 1'b0);
    run_case(2, 1, 0, 1, 0, 3000, 1'b0);
    run_case(3, 1, 1, 1, 1, 6000, 1'b1);
    run_case(5, 0, 0, 0, 1, 3000, 1'b1);
    run_case(255, 1, 1, 0, 1, 4200, 1'b0);
    for (int r = 0; r < 10; r++) begin
      int d, o, m, c, p;
      d = int'($urandom % 16); o = int'($urandom % 2); m = int'($urandom % 2);
      c = int'($urandom % 2); p = int'($urandom % 2);
      run_case(d, o, m, c, p, 5000, ($urandom % 2) == 1);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule